// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer

The block is a 32-bit timer that counts upward in its own clock domain. Software drives it through a small register port: a packed control word, a counter, a load value, a trigger strobe register, a match value, and interrupt status and enable registers. The count advances on every clock, or once per prescaled period when the prescaler is on. When the count passes its all-ones value, the timer either reloads from the load register or stops at zero. The same event, and an optional match against the match register, can raise an interrupt and drive one PWM output pin.

All register writes are single-cycle strobes with address and data. Reads are combinational from a separate read address. The port carries register accesses and no data stream, so it stays plain, with no valid/ready handshake. Clock-domain crossing of software writes is done outside this core.

Top module: `gpt_core`

Offsets (byte address): status 0x18, interrupt enable 0x1C, control 0x24, counter 0x28, load 0x2C, trigger 0x30, match 0x38. Control bits: 0 run, 1 reload enable, 4:2 prescale value, 5 prescale enable, 6 compare enable, 7 PWM idle level, 11:10 PWM event mode, 12 toggle select. Status and enable bits: 0 match, 1 overflow.

## Requirements
- R1: After reset every register reads zero, and `irq` and `pwm_out` are low.
- R2: While run (control bit 0) is set and the prescaler is off, the counter rises by one on every clock. While run is clear it holds. A write to the counter register sets the count on the next edge.
- R3: With prescale enable (bit 5) set and prescale value P (bits 4:2), the counter advances once every 2^(P+1) clocks, first after 2^(P+1) clocks from start.
- R4: When a tick finds the counter at all ones and reload enable (bit 1) is set, the counter takes the load value and status bit 1 (overflow) is set.
- R5: When that overflow happens with reload enable clear, the counter becomes zero, status bit 1 is set, and run (bit 0) clears itself.
- R6: Status bit 0 (match) is set when a tick brings the counter to the match value while compare enable (bit 6) is set. It is never set while bit 6 is clear.
- R7: Writing the status register clears exactly the bits written as one. Other bits keep their value.
- R8: `irq` is high exactly when some status bit and its enable bit (same position) are both one.
- R9: A write of any value to the trigger register copies the load value into the counter on the next edge.
- R10: With toggle select (bit 12) set, `pwm_out` equals the idle level (bit 7) XOR a toggle state. The toggle state inverts on each selected event. Event mode 0 selects no event, mode 1 selects overflow only, and modes 2 and 3 select overflow and match. The toggle state clears while run is clear.
- R11: With toggle select clear, each selected event inverts `pwm_out` from the idle level for exactly one clock, starting on the edge that records the event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq | output | 1 | Interrupt request |
| pwm_out | output | 1 | PWM output pin |

## Verification
A wrong prescaler phase shows up as a counter that reads one count off at a fixed clock offset after start. A wrong overflow or match decode shows up on the edge of the event, in the status register, `irq`, the counter value and the run bit. A stale toggle or pulse state shows on `pwm_out` within one clock of the event or of stopping the timer. Every expected value is pinned to a specific edge counted from the control write, so a one-cycle slip in any register fails the check.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int PRE_W = 3;

  localparam logic [7:0] OFS_STATUS = 8'h18;
  localparam logic [7:0] OFS_IRQEN  = 8'h1C;
  localparam logic [7:0] OFS_CTRL   = 8'h24;
  localparam logic [7:0] OFS_COUNT  = 8'h28;
  localparam logic [7:0] OFS_LOAD   = 8'h2C;
  localparam logic [7:0] OFS_TRIG   = 8'h30;
  localparam logic [7:0] OFS_MATCH  = 8'h38;

  localparam int ST_MATCH = 0;
  localparam int ST_OVF   = 1;
  localparam int ST_W     = 2;

  typedef enum logic [1:0] {
    EVM_NONE = 2'd0,
    EVM_OVF  = 2'd1,
    EVM_BOTH = 2'd2,
    EVM_ALT  = 2'd3
  } evmode_e;

  typedef struct packed {
    logic             toggle_sel;
    evmode_e          ev_mode;
    logic [1:0]       spare;
    logic             idle_lvl;
    logic             cmp_en;
    logic             pre_en;
    logic [PRE_W-1:0] pre_val;
    logic             reload_en;
    logic             run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PRE_W-1:0] pre_val,
  input  logic             restart,
  output logic             tick
);
  localparam int DW = 2 ** PRE_W;

  logic [DW-1:0]  pcnt;
  logic [DW-1:0]  limit;
  logic [PRE_W:0] shamt;

  always_comb begin
    shamt = {1'b0, pre_val} + (PRE_W+1)'(1);
    limit = (DW'(1) << shamt) - DW'(1);
    tick  = run && (!pre_en || (pcnt == limit));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                pcnt <= '0;
    else if (!run || restart || !pre_en || tick) pcnt <= '0;
    else                                       pcnt <= pcnt + DW'(1);
  end

  // R3: a divided tick is never followed by another on the next clock
  assert_div_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_en) |=> (!tick || !pre_en));
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload_en,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             trig_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             match_evt
);
  logic             sw_hit;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    sw_hit    = cnt_wr || trig_wr;
    ovf_evt   = tick && !sw_hit && (&cnt);
    cnt_nx    = ovf_evt ? (reload_en ? load_val : '0) : cnt + CNT_W'(1);
    match_evt = tick && !sw_hit && cmp_en && (cnt_nx == match_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_wr) cnt <= cnt_wdata;
    else if (trig_wr) cnt <= load_val;
    else if (tick)   cnt <= cnt_nx;
  end

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && reload_en) |=> (cnt == $past(load_val)));
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !reload_en) |=> (cnt == '0));
  assert_trigger_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && !cnt_wr) |=> (cnt == $past(load_val)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sw_hit) |=> $stable(cnt));
endmodule

// File: rtl/gpt_pwm.sv
module gpt_pwm
  import gpt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    idle_lvl,
  input  logic    toggle_sel,
  input  evmode_e ev_mode,
  input  logic    ovf_evt,
  input  logic    match_evt,
  output logic    pwm_out
);
  logic sel_evt;
  logic tog_q;
  logic pulse_q;

  always_comb begin
    case (ev_mode)
      EVM_NONE: sel_evt = 1'b0;
      EVM_OVF:  sel_evt = ovf_evt;
      default:  sel_evt = ovf_evt || match_evt;
    endcase
    pwm_out = idle_lvl ^ (toggle_sel ? tog_q : pulse_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= sel_evt && !toggle_sel;
      if (!run)                        tog_q <= 1'b0;
      else if (sel_evt && toggle_sel)  tog_q <= ~tog_q;
    end
  end

  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tog_q);
  assert_mode_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ev_mode == EVM_NONE) |=> ($stable(tog_q) && !pulse_q));
endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq,
  output logic              pwm_out
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q, match_q, cnt;
  logic [ST_W-1:0]  status_q, irqen_q, st_set, st_clr;
  logic             wr_ctrl, wr_cnt, wr_load, wr_trig, wr_match, wr_stat, wr_ien;
  logic             tick, ovf_evt, match_evt;

  always_comb begin
    wr_ctrl  = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    wr_cnt   = wr_en && (wr_addr == ADDR_W'(OFS_COUNT));
    wr_load  = wr_en && (wr_addr == ADDR_W'(OFS_LOAD));
    wr_trig  = wr_en && (wr_addr == ADDR_W'(OFS_TRIG));
    wr_match = wr_en && (wr_addr == ADDR_W'(OFS_MATCH));
    wr_stat  = wr_en && (wr_addr == ADDR_W'(OFS_STATUS));
    wr_ien   = wr_en && (wr_addr == ADDR_W'(OFS_IRQEN));
    st_set           = '0;
    st_set[ST_MATCH] = match_evt;
    st_set[ST_OVF]   = ovf_evt;
    st_clr = wr_stat ? wr_data[ST_W-1:0] : '0;
    irq    = |(status_q & irqen_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      load_q   <= '0;
      match_q  <= '0;
      status_q <= '0;
      irqen_q  <= '0;
    end else begin
      if (wr_ctrl)                            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      else if (ovf_evt && !ctrl_q.reload_en)  ctrl_q.run <= 1'b0;
      if (wr_load)  load_q  <= wr_data;
      if (wr_match) match_q <= wr_data;
      if (wr_ien)   irqen_q <= wr_data[ST_W-1:0];
      status_q <= (status_q & ~st_clr) | st_set;
    end
  end

  gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .pre_en(ctrl_q.pre_en),
    .pre_val(ctrl_q.pre_val), .restart(wr_cnt || wr_trig), .tick(tick)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload_en(ctrl_q.reload_en),
    .cmp_en(ctrl_q.cmp_en), .load_val(load_q), .match_val(match_q),
    .cnt_wr(wr_cnt), .cnt_wdata(wr_data), .trig_wr(wr_trig),
    .cnt(cnt), .ovf_evt(ovf_evt), .match_evt(match_evt)
  );

  gpt_pwm u_pwm (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .idle_lvl(ctrl_q.idle_lvl),
    .toggle_sel(ctrl_q.toggle_sel), .ev_mode(ctrl_q.ev_mode),
    .ovf_evt(ovf_evt), .match_evt(match_evt), .pwm_out(pwm_out)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(OFS_CTRL):   rd_data = CNT_W'(ctrl_q);
      ADDR_W'(OFS_COUNT):  rd_data = cnt;
      ADDR_W'(OFS_LOAD):   rd_data = load_q;
      ADDR_W'(OFS_MATCH):  rd_data = match_q;
      ADDR_W'(OFS_STATUS): rd_data = CNT_W'(status_q);
      ADDR_W'(OFS_IRQEN):  rd_data = CNT_W'(irqen_q);
      default:             rd_data = '0;
    endcase
  end

  assert_self_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !ctrl_q.reload_en && !wr_ctrl) |=> !ctrl_q.run);
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wr_data[ST_OVF] && !ovf_evt) |=> !status_q[ST_OVF]);
  assert_match_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[ST_MATCH] && !(wr_stat && wr_data[ST_MATCH])) |=> status_q[ST_MATCH]);
  assert_no_match_without_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.cmp_en && !status_q[ST_MATCH]) |=> !status_q[ST_MATCH]);
endmodule

// File: tb/gpt_core_bench.sv
`timescale 1ns/1ps
module gpt_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, pwm_out;

  always #2.5 clk = ~clk;

  gpt_core u_gpt_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .pwm_out(pwm_out)
  );

  localparam logic [7:0] A_ST = 8'h18, A_IE = 8'h1C, A_CT = 8'h24, A_CN = 8'h28,
                         A_LD = 8'h2C, A_TG = 8'h30, A_MT = 8'h38;
  localparam int K_RD = 0, K_IRQ = 1, K_PWM = 2;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t queue_q[$];
  event  smp_ev;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  // Driver: pushes an expected item, then lets the monitor sample
  task automatic chk(int kind, logic [7:0] addr, logic [31:0] exp, string req);
    item_t it;
    rd_addr = addr;
    it.kind = kind; it.exp = exp; it.req = req;
    queue_q.push_back(it);
    -> smp_ev;
    #0.5;
  endtask

  task automatic wr(logic [7:0] addr, logic [31:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(smp_ev);
      #0.2;
      while (queue_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = queue_q.pop_front();
        case (it.kind)
          K_IRQ:   act = {31'b0, irq};
          K_PWM:   act = {31'b0, pwm_out};
          default: act = rd_data;
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=0x%08h expected=0x%08h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    chk(K_RD, A_CT, 32'h0, "R1 ctrl");
    chk(K_RD, A_CN, 32'h0, "R1 counter");
    chk(K_RD, A_ST, 32'h0, "R1 status");
    chk(K_IRQ, 8'h0, 32'h0, "R1 irq");
    wait_cyc(1);
    chk(K_PWM, 8'h0, 32'h0, "R1 pwm");
    chk(K_RD, A_LD, 32'h0, "R1 load");

    // R2 plain counting
    wr(A_CN, 32'd10);
    wr(A_CT, 32'h1);
    wait_cyc(5);
    chk(K_RD, A_CN, 32'd15, "R2 count+5");
    wr(A_CT, 32'h0);
    wait_cyc(2);
    chk(K_RD, A_CN, 32'd16, "R2 hold when stopped");

    // R4 reload + R10 toggle on overflow + R8 irq
    wr(A_LD, 32'd100);
    wr(A_CN, 32'hFFFF_FFFE);
    wr(A_IE, 32'h2);
    wr(A_CT, 32'h1403);
    wait_cyc(2);
    chk(K_RD, A_CN, 32'd100, "R4 reload value");
    chk(K_RD, A_ST, 32'h2, "R4 overflow status");
    chk(K_IRQ, 8'h0, 32'h1, "R8 irq enabled");
    chk(K_PWM, 8'h0, 32'h1, "R10 toggle on overflow");
    wait_cyc(3);
    chk(K_RD, A_CN, 32'd103, "R2 count after reload");
    wr(A_ST, 32'h2);
    chk(K_RD, A_ST, 32'h0, "R7 clear overflow");
    chk(K_IRQ, 8'h0, 32'h0, "R8 irq drops");
    wr(A_CT, 32'h0);
    wait_cyc(1);
    chk(K_PWM, 8'h0, 32'h0, "R10 stopped returns idle");
    chk(K_RD, A_CN, 32'd105, "R2 stopped count");

    // R6 match + R11 pulse
    wr(A_IE, 32'h1);
    wr(A_MT, 32'd20);
    wr(A_CN, 32'd15);
    wr(A_CT, 32'h841);
    wait_cyc(4);
    chk(K_RD, A_CN, 32'd19, "R2 before match");
    chk(K_PWM, 8'h0, 32'h0, "R11 no pulse yet");
    wait_cyc(1);
    chk(K_RD, A_ST, 32'h1, "R6 match status");
    chk(K_IRQ, 8'h0, 32'h1, "R8 match irq");
    chk(K_PWM, 8'h0, 32'h1, "R11 pulse high");
    wait_cyc(1);
    chk(K_PWM, 8'h0, 32'h0, "R11 pulse one clock");
    wr(A_CT, 32'h0);

    // R6 compare disabled ignores match
    wr(A_ST, 32'h1);
    wr(A_CN, 32'd15);
    wr(A_CT, 32'h801);
    wait_cyc(6);
    chk(K_RD, A_CN, 32'd21, "R2 passes match value");
    chk(K_RD, A_ST, 32'h0, "R6 no match without compare");
    chk(K_PWM, 8'h0, 32'h0, "R11 no pulse without event");
    wr(A_CT, 32'h0);

    // R10 mode 0: overflow does not move the output
    wr(A_CN, 32'hFFFF_FFFF);
    wr(A_CT, 32'h1003);
    wait_cyc(1);
    chk(K_RD, A_CN, 32'd100, "R4 reload mode0");
    chk(K_PWM, 8'h0, 32'h0, "R10 mode0 no toggle");
    wr(A_CT, 32'h0);
    wr(A_ST, 32'h3);

    // R5 no-reload overflow, plus simultaneous match at zero
    wr(A_IE, 32'h0);
    wr(A_MT, 32'h0);
    wr(A_CN, 32'hFFFF_FFFF);
    wr(A_CT, 32'h41);
    wait_cyc(1);
    chk(K_RD, A_CN, 32'h0, "R5 wraps to zero");
    chk(K_RD, A_CT, 32'h40, "R5 run self-clears");
    chk(K_RD, A_ST, 32'h3, "R5 overflow and R6 match");
    chk(K_IRQ, 8'h0, 32'h0, "R8 masked irq");
    wait_cyc(3);
    chk(K_RD, A_CN, 32'h0, "R5 stays stopped");
    wr(A_ST, 32'h1);
    chk(K_RD, A_ST, 32'h2, "R7 clear only written bit");
    wr(A_IE, 32'h2);
    chk(K_IRQ, 8'h0, 32'h1, "R8 enable raises irq");
    wr(A_ST, 32'h2);
    chk(K_IRQ, 8'h0, 32'h0, "R8 irq after clear");

    // R3 prescaler, P=1 -> every 4 clocks
    wr(A_CN, 32'h0);
    wr(A_CT, 32'h25);
    wait_cyc(3);
    chk(K_RD, A_CN, 32'd0, "R3 before first tick");
    wait_cyc(1);
    chk(K_RD, A_CN, 32'd1, "R3 first tick");
    wait_cyc(4);
    chk(K_RD, A_CN, 32'd2, "R3 second tick");
    wr(A_CT, 32'h0);

    // R9 trigger write
    wr(A_LD, 32'd500);
    wr(A_CN, 32'd7);
    wr(A_TG, 32'hDEAD);
    chk(K_RD, A_CN, 32'd500, "R9 trigger copies load");
    chk(K_RD, A_TG, 32'h0, "R9 trigger reads zero");

    wait_cyc(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule